// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Order

This block produces the internal address for a burst-capable synchronous memory. On a rising clock edge where an address strobe is accepted, it takes the full external address. While the advance input stays active afterwards, it steps the two lowest address bits through a four-beat burst on its own. The upper bits keep the value that was loaded. A new address can be loaded on any clock, so a host that does not use bursts can present a fresh address every cycle with no penalty.

There are two active-low load strobes. The processor-side strobe counts only while chip enable is high. The controller-side strobe always loads. In both cases chip enable, sampled at the load, sets the burst-active flag that qualifies the access. The order select is captured together with the address. A value of 0 selects linear order, which adds the beat index to the start value modulo 4. A value of 1 selects interleaved order, which XORs the start value with the beat index. Because the order is captured, a change on the order pin during a burst has no effect until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, addr_out is all zeros and burst_act is 0 until the first load.
- R2: When ctrl_strb_n is 0 at a rising edge, addr_out equals the sampled addr_in after that edge, whatever the value of chip_en.
- R3: When proc_strb_n is 0 at a rising edge with chip_en 1, addr_in is loaded. With chip_en 0, ctrl_strb_n 1 and adv_n 1, the edge leaves addr_out and burst_act unchanged.
- R4: After a load, burst_act equals the chip_en value sampled at that edge. Edges without a load leave burst_act unchanged.
- R5: With order 0 (linear) captured, the low two bits after k advances are (start + k) mod 4.
- R6: With order 1 (interleaved) captured, the low two bits after k advances are start XOR (k mod 4).
- R7: After four advances the address returns to the loaded value. The upper address bits never change on an advance.
- R8: An accepted strobe and adv_n 0 in the same cycle load addr_in. No advance takes place.
- R9: An edge with no accepted strobe and adv_n 1 holds addr_out.
- R10: order_sel is sampled only at a load. Changing it during a burst does not alter the sequence.
- R11: Loads on consecutive clocks each show the newly sampled address one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, gated by chip_en |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low, ungated |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current internal address |
| burst_act | output | 1 | Access is qualified by chip enable |

## Verification
On every cycle, the bound checker confirms four things. A load shows the sampled address and chip enable one edge later. Idle edges and ignored processor strobes leave the outputs frozen. An advance keeps the upper bits and always moves the low bits. The exact beat values in each order, the return to the start after four beats, the capture of the order at load time and the reset state depend on several cycles of history. Only the bench shows these. It sweeps both orders, every start value and several upper-bit patterns through more than one wrap.

// File: rtl/bas_pkg.sv
package bas_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } bas_order_e;

   typedef struct packed {
      logic load;   // capture addr_in this edge
      logic step;   // advance the beat index this edge
      logic sel;    // chip enable value to record on load
   } bas_ctl_t;
endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
   import bas_pkg::*;
(
   input  logic     chip_en,
   input  logic     proc_strb_n,
   input  logic     ctrl_strb_n,
   input  logic     adv_n,
   output bas_ctl_t ctl
);
   logic proc_ok;
   logic ctrl_ok;

   always_comb begin
      proc_ok  = ~proc_strb_n & chip_en;
      ctrl_ok  = ~ctrl_strb_n;
      ctl.load = proc_ok | ctrl_ok;
      // a strobe always wins over advance
      ctl.step = ~adv_n & ~ctl.load;
      ctl.sel  = chip_en;
   end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BEAT_W-1:0] beat
);
   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat <= '0;
      else if (load)
         beat <= '0;
      else if (step)
         beat <= beat + ONE;  // wraps modulo 2**BEAT_W
   end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import bas_pkg::*;
#(
   parameter int BEAT_W        = 2,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] beat,
   input  bas_order_e        order,
   output logic [BEAT_W-1:0] low
);
   logic [BEAT_W-1:0] lin_val;
   logic [BEAT_W-1:0] il_val;

   assign lin_val = start + beat;

   genvar b;
   generate
      if (INTERLEAVE_EN) begin : g_il
         for (b = 0; b < BEAT_W; b++) begin : g_bit
            assign il_val[b] = start[b] ^ beat[b];
         end
      end else begin : g_lin_only
         assign il_val = lin_val;
      end
   endgenerate

   always_comb begin
      unique case (order)
         ORD_INTERLEAVE: low = il_val;
         default:        low = lin_val;
      endcase
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int BEAT_W        = 2,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              proc_strb_n,
   input  logic              ctrl_strb_n,
   input  logic              adv_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic              burst_act
);
   localparam int UP_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: BEAT_W must be in 1..ADDR_W-1");
      end
   endgenerate

   bas_ctl_t          ctl;
   logic [UP_W-1:0]   upper_q;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] low;
   bas_order_e        order_q;
   logic              act_q;

   bas_strobe_arb u_arb (
      .chip_en     (chip_en),
      .proc_strb_n (proc_strb_n),
      .ctrl_strb_n (ctrl_strb_n),
      .adv_n       (adv_n),
      .ctl         (ctl)
   );

   bas_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ctl.load),
      .step  (ctl.step),
      .beat  (beat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
         order_q <= ORD_LINEAR;
         act_q   <= 1'b0;
      end else if (ctl.load) begin
         upper_q <= addr_in[ADDR_W-1:BEAT_W];
         start_q <= addr_in[BEAT_W-1:0];
         order_q <= bas_order_e'(order_sel);
         act_q   <= ctl.sel;
      end
   end

   bas_order_map #(
      .BEAT_W        (BEAT_W),
      .INTERLEAVE_EN (INTERLEAVE_EN)
   ) u_map (
      .start (start_q),
      .beat  (beat),
      .order (order_q),
      .low   (low)
   );

   assign addr_out  = {upper_q, low};
   assign burst_act = act_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              proc_strb_n,
   input logic              ctrl_strb_n,
   input logic              adv_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out,
   input logic              burst_act
);
   logic take;
   assign take = ~ctrl_strb_n | (~proc_strb_n & chip_en);

   // R2 R8 R11
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> addr_out == $past(addr_in));

   // R4
   act_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> burst_act == $past(chip_en));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && adv_n) |=> ($stable(addr_out) && $stable(burst_act)));

   // R3
   proc_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strb_n && !chip_en && ctrl_strb_n && adv_n) |=>
         ($stable(addr_out) && $stable(burst_act)));

   // R7
   adv_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !adv_n) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

   // R5 R6
   adv_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !adv_n) |=> addr_out[BEAT_W-1:0] != $past(addr_out[BEAT_W-1:0]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chip_en     (chip_en),
   .proc_strb_n (proc_strb_n),
   .ctrl_strb_n (ctrl_strb_n),
   .adv_n       (adv_n),
   .addr_in     (addr_in),
   .addr_out    (addr_out),
   .burst_act   (burst_act)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          chip_en, proc_strb_n, ctrl_strb_n, adv_n, order_sel;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] addr_out;
   logic          burst_act;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2), .INTERLEAVE_EN(1'b1)) i_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .proc_strb_n(proc_strb_n),
      .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .order_sel(order_sel),
      .addr_in(addr_in), .addr_out(addr_out), .burst_act(burst_act)
   );

   function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] base,
                                                 input int k, input bit il);
      logic [1:0] s;
      logic [1:0] lo;
      s  = base[1:0];
      lo = il ? (s ^ 2'(k % 4)) : 2'((int'(s) + k) % 4);
      return {base[AW-1:2], lo};
   endfunction

   task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_act);
      checks++;
      if (addr_out !== exp_a || burst_act !== exp_act) begin
         failures++;
         $display("FAIL %s: addr_out=%h act=%b expected addr=%h act=%b",
                  req, addr_out, burst_act, exp_a, exp_act);
      end
   endtask

   // drive at negedge, let one rising edge pass, sample 1 ns later
   task automatic cycle(input logic ce, input logic ps, input logic cs,
                        input logic av, input logic ord, input logic [AW-1:0] a);
      @(negedge clk);
      chip_en = ce; proc_strb_n = ps; ctrl_strb_n = cs; adv_n = av;
      order_sel = ord; addr_in = a;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] base;
      rst_n = 1'b0; chip_en = 1'b0; proc_strb_n = 1'b1; ctrl_strb_n = 1'b1;
      adv_n = 1'b1; order_sel = 1'b0; addr_in = '0;
      #23;
      check("R1 in reset", '0, 1'b0);
      rst_n = 1'b1;
      cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5);
      check("R1 after reset", '0, 1'b0);

      // R5 R6 R7: both orders, all start values, several uppers, two wraps
      for (int ord = 0; ord < 2; ord++) begin
         for (int up = 0; up < 4; up++) begin
            for (int s = 0; s < 4; s++) begin
               base = {6'(up * 13 + 5), 2'(s)};
               cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'(ord), base);
               check("R2 load", base, 1'b1);
               for (int k = 1; k <= 8; k++) begin
                  cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'(ord), ~base);
                  check(ord ? "R6 interleaved beat" : "R5 linear beat",
                        expect_addr(base, k, ord != 0), 1'b1);
                  if (k == 4) check("R7 wrap to start", base, 1'b1);
               end
            end
         end
      end

      // R2 R4: controller strobe loads with chip_en low, act follows
      cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3E);
      check("R2 ctrl load ce=0 / R4", 8'h3E, 1'b0);
      // R9 hold
      cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
      check("R9 hold", 8'h3E, 1'b0);
      // R3 proc strobe ignored with chip_en low
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81);
      check("R3 proc ignored", 8'h3E, 1'b0);
      // R3 proc strobe accepted with chip_en high
      cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81);
      check("R3 proc load / R4", 8'h81, 1'b1);
      // R8 strobe beats advance
      cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h92);
      check("R8 strobe wins", 8'h92, 1'b1);
      cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h17);
      check("R8 ctrl strobe wins", 8'h17, 1'b1);
      // R10: captured interleaved (start 3), order pin flips to linear
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R10 order kept beat1", 8'h16, 1'b1);
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R10 order kept beat2", 8'h15, 1'b1);
      // R10 reverse: linear captured, pin set interleaved
      cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h42);
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
      check("R10 linear kept beat1", 8'h43, 1'b1);
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
      check("R10 linear kept beat2", 8'h40, 1'b1);
      // R4: advance does not touch act; ctrl load with ce=0 clears it
      cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R4 act unchanged on advance", 8'h41, 1'b1);
      // R11: back-to-back loads on consecutive clocks
      for (int i = 0; i < 12; i++) begin
         base = 8'(i * 37 + 11);
         cycle(1'(i % 2), 1'b1, 1'b0, 1'(i % 3 == 0), 1'b0, base);
         check("R11 back-to-back", base, 1'(i % 2));
      end
      // R1 again: asynchronous reset mid-burst
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1 async reset", '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule